// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns characters into an asynchronous or clocked serial bit stream on a single output line. Software or a host engine writes a character of up to nine bits into a one-entry holding register. The shifter then emits a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. The character width (5 to 9 bits), the parity type (none, even, odd) and the stop count (1 or 2) are picked by three control fields, which gives thirty frame shapes.

Bit timing comes from outside. In asynchronous operation a one-cycle strobe from a rate generator advances the frame by one bit. In clocked operation the line instead advances on one edge of a bit clock that is already synchronous to the system clock, and a polarity input picks the rising or the falling edge. A second character may be written while the first is still shifting, so frames can follow each other with no idle bit between them. Two flags report progress: one says the holding register can take a character, the other says the line has gone quiet after the last stop bit.

Top module: `sertx_core`

## Requirements
- R1: A frame opens with one low start bit, then the data bits, least significant first; `len_sel` values 0, 1, 2, 3, 4 give 5, 6, 7, 8, 9 data bits and values 5 to 7 give 8 bits. The format fields are captured when the start bit is launched and hold for that whole frame.
- R2: `par_sel` 2 selects even and 3 selects odd parity, while 0 and 1 send no parity bit; the parity bit follows the last data bit and equals the XOR of the sent data bits, inverted for odd.
- R3: `stop2` low sends one high stop bit after the data or parity bit; `stop2` high sends two.
- R4: With `sync_mode` low, `txd` changes only at a clock edge where `bit_tick` is high, and each such edge moves the frame on by exactly one bit.
- R5: With `sync_mode` high, `txd` changes only at the first clock edge after `xck` rises (when `xck_pol` is 0) or falls (when `xck_pol` is 1), one bit per such edge.
- R6: Between frames `txd` is high; when a character is waiting at the end of the last stop bit, its start bit follows at the very next bit step.
- R7: `dre` is high when the holding register is empty; an accepted write clears it, the move of the character into the shifter sets it, and a write while `dre` is low is dropped.
- R8: `txc` goes high at the bit step that ends the last stop bit when no character is waiting, and never at any other time; `txc_clr` clears it, and a set in the same cycle wins.
- R9: While `tx_en` is low, `txd_oe` is low, `txd` is high, any frame in progress is abandoned, the holding register is emptied and writes are dropped.
- R10: After reset `txd` is high, `dre` is high, `txc` is low and no frame is in progress.
- R11: A write that arrives in the same cycle as a bit step while the line is idle launches its start bit at that step, and `dre` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle bit step from the rate generator (asynchronous operation) |
| sync_mode | input | 1 | 1 selects clocked operation driven by `xck` |
| xck | input | 1 | Bit clock, already synchronous to `clk` |
| xck_pol | input | 1 | 0: step on rising `xck`, 1: step on falling `xck` |
| tx_en | input | 1 | Transmitter enable |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W-1 | Low data bits of the character |
| wr_msb | input | 1 | Ninth data bit |
| len_sel | input | 3 | Character width code |
| par_sel | input | 2 | Parity code |
| stop2 | input | 1 | 1 selects two stop bits |
| txc_clr | input | 1 | Clears the transmit-complete flag |
| txd | output | 1 | Serial data line |
| txd_oe | output | 1 | Line drive enable |
| dre | output | 1 | Holding register empty |
| txc | output | 1 | Transmit complete |

## Verification
The assertions assume that `xck` is already synchronous to `clk` and that a bit step never arrives on two consecutive cycles of the same frame bit, so a hold between steps is meaningful. They also take the format fields as stable only at launch, not across a frame. The stimulus respects this: steps come every fourth cycle or every third cycle of the bit clock, the format changes only while the line is drained or between writes after the previous character has been launched, and the enable drops only at a chosen point followed by a flush of the expected stream.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP1 = 3'd4,
      ST_STOP2 = 3'd5
   } tx_state_e;

   localparam int unsigned MIN_CHAR_BITS = 5;
   localparam int unsigned MAX_CHAR_BITS = 9;
   localparam int unsigned FALLBACK_BITS = 8;

   // width code -> number of data bits
   function automatic int unsigned width_of_code(input logic [2:0] code);
      int unsigned n;
      if (code <= 3'd4) n = MIN_CHAR_BITS + int'(code);
      else              n = FALLBACK_BITS;
      return n;
   endfunction

endpackage

// File: rtl/sertx_strobe.sv
`timescale 1ns/1ps
module sertx_strobe #(
   parameter bit SYNC_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic sync_mode,
   input  logic xck,
   input  logic xck_pol,
   output logic strobe
);

   generate
      if (SYNC_EN) begin : g_sync
         logic xck_q;
         logic xck_rise;
         logic xck_fall;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) xck_q <= 1'b0;
            else        xck_q <= xck;
         end

         assign xck_rise = xck & ~xck_q;
         assign xck_fall = ~xck & xck_q;
         assign strobe   = sync_mode ? (xck_pol ? xck_fall : xck_rise) : bit_tick;
      end else begin : g_async
         logic unused_sync_pins;
         assign unused_sync_pins = ^{sync_mode, xck, xck_pol, clk, rst_n};
         assign strobe = bit_tick;
      end
   endgenerate

endmodule

// File: rtl/sertx_wbuf.sv
`timescale 1ns/1ps
module sertx_wbuf #(
   parameter int unsigned DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_word,
   input  logic              take,
   output logic              pend_valid,
   output logic [DATA_W-1:0] pend_word,
   output logic              empty
);

   logic              full_q;
   logic [DATA_W-1:0] word_q;
   logic              accept;

   assign accept     = en & wr_valid & ~full_q;
   assign pend_valid = full_q | accept;
   assign pend_word  = full_q ? word_q : wr_word;
   assign empty      = ~full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      full_q <= 1'b0;
      else if (!en)    full_q <= 1'b0;
      else if (take)   full_q <= 1'b0;
      else if (accept) full_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                word_q <= '0;
      else if (accept && !take)  word_q <= wr_word;
   end

endmodule

// File: rtl/sertx_parity.sv
`timescale 1ns/1ps
module sertx_parity #(
   parameter int unsigned DATA_W = 9,
   parameter int unsigned CW     = $clog2(DATA_W + 1)
) (
   input  logic [DATA_W-1:0] word,
   input  logic [CW-1:0]     nbits,
   input  logic              odd,
   output logic              par
);

   logic acc;

   always_comb begin
      acc = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < int'(nbits)) acc = acc ^ word[i];
      end
      par = acc ^ odd;
   end

endmodule

// File: rtl/sertx_shift.sv
`timescale 1ns/1ps
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              strobe,
   input  logic              pend_valid,
   input  logic [DATA_W-1:0] pend_word,
   input  logic [2:0]        len_sel,
   input  logic [1:0]        par_sel,
   input  logic              stop2,
   input  logic              txc_clr,
   output logic              take,
   output logic              txd,
   output logic              busy,
   output logic              txc
);

   localparam int unsigned CW = $clog2(DATA_W + 1);

   tx_state_e         state_q;
   logic [DATA_W-1:0] sh_q;
   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     nb_q;
   logic              par_q;
   logic              par_en_q;
   logic              two_q;
   logic              txd_q;
   logic              txc_q;

   logic [CW-1:0]     nb_new;
   logic              par_new;
   logic              frame_end;

   always_comb begin
      int unsigned n;
      n = width_of_code(len_sel);
      if (n > DATA_W) n = DATA_W;
      nb_new = CW'(n);
   end

   sertx_parity #(.DATA_W(DATA_W), .CW(CW)) u_par (
      .word  (pend_word),
      .nbits (nb_new),
      .odd   (par_sel[0]),
      .par   (par_new)
   );

   assign frame_end = ((state_q == ST_STOP1) && !two_q) || (state_q == ST_STOP2);
   assign take      = en & strobe & pend_valid & ((state_q == ST_IDLE) | frame_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         txd_q    <= 1'b1;
         sh_q     <= '0;
         cnt_q    <= '0;
         nb_q     <= '0;
         par_q    <= 1'b0;
         par_en_q <= 1'b0;
         two_q    <= 1'b0;
      end else if (!en) begin
         state_q <= ST_IDLE;
         txd_q   <= 1'b1;
      end else if (take) begin
         state_q  <= ST_START;
         txd_q    <= 1'b0;
         sh_q     <= pend_word;
         cnt_q    <= '0;
         nb_q     <= nb_new;
         par_q    <= par_new;
         par_en_q <= par_sel[1];
         two_q    <= stop2;
      end else if (strobe) begin
         case (state_q)
            ST_START: begin
               txd_q   <= sh_q[0];
               sh_q    <= sh_q >> 1;
               cnt_q   <= CW'(1);
               state_q <= ST_DATA;
            end
            ST_DATA: begin
               if (cnt_q == nb_q) begin
                  if (par_en_q) begin
                     txd_q   <= par_q;
                     state_q <= ST_PAR;
                  end else begin
                     txd_q   <= 1'b1;
                     state_q <= ST_STOP1;
                  end
               end else begin
                  txd_q <= sh_q[0];
                  sh_q  <= sh_q >> 1;
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_PAR: begin
               txd_q   <= 1'b1;
               state_q <= ST_STOP1;
            end
            ST_STOP1: begin
               txd_q   <= 1'b1;
               state_q <= two_q ? ST_STOP2 : ST_IDLE;
            end
            ST_STOP2: begin
               txd_q   <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: begin
               txd_q   <= 1'b1;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                       txc_q <= 1'b0;
      else if (en && strobe && frame_end && !pend_valid) txc_q <= 1'b1;
      else if (txc_clr)                                 txc_q <= 1'b0;
   end

   assign txd  = txd_q;
   assign busy = (state_q != ST_IDLE);
   assign txc  = txc_q;

endmodule

// File: rtl/sertx_core.sv
`timescale 1ns/1ps
module sertx_core #(
   parameter int unsigned DATA_W  = 9,
   parameter bit          SYNC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              sync_mode,
   input  logic              xck,
   input  logic              xck_pol,
   input  logic              tx_en,
   input  logic              wr_valid,
   input  logic [DATA_W-2:0] wr_data,
   input  logic              wr_msb,
   input  logic [2:0]        len_sel,
   input  logic [1:0]        par_sel,
   input  logic              stop2,
   input  logic              txc_clr,
   output logic              txd,
   output logic              txd_oe,
   output logic              dre,
   output logic              txc
);

   generate
      if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
         $error("sertx_core: DATA_W must lie between 5 and 9");
      end
   endgenerate

   logic              strobe;
   logic              pend_valid;
   logic [DATA_W-1:0] pend_word;
   logic              take;
   logic              busy;

   sertx_strobe #(.SYNC_EN(SYNC_EN)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .sync_mode (sync_mode),
      .xck       (xck),
      .xck_pol   (xck_pol),
      .strobe    (strobe)
   );

   sertx_wbuf #(.DATA_W(DATA_W)) u_wbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (tx_en),
      .wr_valid   (wr_valid),
      .wr_word    ({wr_msb, wr_data}),
      .take       (take),
      .pend_valid (pend_valid),
      .pend_word  (pend_word),
      .empty      (dre)
   );

   sertx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (tx_en),
      .strobe     (strobe),
      .pend_valid (pend_valid),
      .pend_word  (pend_word),
      .len_sel    (len_sel),
      .par_sel    (par_sel),
      .stop2      (stop2),
      .txc_clr    (txc_clr),
      .take       (take),
      .txd        (txd),
      .busy       (busy),
      .txc        (txc)
   );

   assign txd_oe = tx_en;

endmodule

// File: rtl/sertx_chk.sv
`timescale 1ns/1ps
module sertx_chk #(
   parameter int unsigned DATA_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strobe,
   input logic              tx_en,
   input logic              wr_valid,
   input logic              txd,
   input logic              dre,
   input logic              txc,
   input logic              busy,
   input logic [DATA_W-1:0] held_word
);

   // R4
   txd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !strobe) |=> $stable(txd));

   // R6
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !busy) |-> txd);

   // R1
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && $rose(busy)) |-> !txd);

   // R7
   drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && wr_valid && !dre) |=> $stable(held_word));

   // R7
   dre_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dre) |-> $past(wr_valid && tx_en));

   // R8
   txc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txc) |-> (dre && !busy));

endmodule

bind sertx_core sertx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .strobe    (strobe),
   .tx_en     (tx_en),
   .wr_valid  (wr_valid),
   .txd       (txd),
   .dre       (dre),
   .txc       (txc),
   .busy      (busy),
   .held_word (u_wbuf.word_q)
);

// File: tb/sim_sertx_core.sv
`timescale 1ns/1ps
module sim_sertx_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       sync_mode = 1'b0;
   logic       xck = 1'b0;
   logic       xck_pol = 1'b0;
   logic       tx_en = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_msb = 1'b0;
   logic [2:0] len_sel = 3'd3;
   logic [1:0] par_sel = 2'd0;
   logic       stop2 = 1'b0;
   logic       txc_clr = 1'b0;
   logic       txd, txd_oe, dre, txc;

   int checks = 0;
   int errors = 0;

   logic qv[$];
   string qt[$];

   logic str_seen = 1'b0;
   logic xd = 1'b0;
   logic last_txd = 1'b1;
   logic last_txc = 1'b0;
   bit   pend_end = 1'b0;
   int   tcnt = 0;
   int   xcnt = 0;

   always #5 clk = ~clk;

   sertx_core u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sync_mode(sync_mode),
      .xck(xck), .xck_pol(xck_pol), .tx_en(tx_en), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_msb(wr_msb), .len_sel(len_sel), .par_sel(par_sel),
      .stop2(stop2), .txc_clr(txc_clr), .txd(txd), .txd_oe(txd_oe),
      .dre(dre), .txc(txc)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // bit-step sources: tick every 4th cycle, bit clock toggling every 3 cycles
   always @(negedge clk) begin
      tcnt = (tcnt + 1) % 4;
      bit_tick = (tcnt == 0) && !sync_mode;
      xcnt = (xcnt + 1) % 3;
      if (sync_mode && xcnt == 0) xck = ~xck;
   end

   // when the design is due to take a bit step, per R4 / R5
   always @(posedge clk) begin
      str_seen <= sync_mode ? (xck_pol ? (xd & ~xck) : (~xd & xck)) : bit_tick;
      xd <= xck;
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && tx_en) begin
         if (txc && !last_txc && !pend_end)
            chk(1'b0, "R8", "txc rose mid-stream", 1, 0);
         if (str_seen) begin
            if (qv.size() > 0) begin
               logic ev;
               string tg;
               ev = qv.pop_front();
               tg = qt.pop_front();
               chk(txd === ev, tg, "frame bit", int'(txd), int'(ev));
               if (qv.size() == 0) pend_end = 1'b1;
            end else begin
               chk(txd === 1'b1, "R6", "idle line", int'(txd), 1);
               if (pend_end) begin
                  chk(txc === 1'b1, "R8", "txc after last stop", int'(txc), 1);
                  chk(dre === 1'b1, "R7", "dre after drain", int'(dre), 1);
                  pend_end = 1'b0;
               end
            end
         end else begin
            chk(txd === last_txd, sync_mode ? "R5" : "R4", "hold between steps",
                int'(txd), int'(last_txd));
         end
      end
      last_txd = txd;
      last_txc = txc;
   end

   function automatic void push_frame(input logic [8:0] d, input int nb,
                                      input int pm, input bit two);
      logic p;
      p = 1'b0;
      qv.push_back(1'b0); qt.push_back("R1");
      for (int i = 0; i < nb; i++) begin
         qv.push_back(d[i]); qt.push_back("R1");
         p = p ^ d[i];
      end
      if (pm >= 2) begin
         qv.push_back(p ^ (pm == 3)); qt.push_back("R2");
      end
      qv.push_back(1'b1); qt.push_back("R3");
      if (two) begin
         qv.push_back(1'b1); qt.push_back("R3");
      end
   endfunction

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic send(input logic [8:0] d, input int nb, input int pm, input bit two);
      step();
      while (dre !== 1'b1) step();
      len_sel = 3'(nb - 5); par_sel = 2'(pm); stop2 = two;
      wr_data = d[7:0]; wr_msb = d[8]; wr_valid = 1'b1;
      @(posedge clk);
      push_frame(d, nb, pm, two);
      step();
      wr_valid = 1'b0;
   endtask

   task automatic poke(input logic [8:0] d);
      wr_data = d[7:0]; wr_msb = d[8]; wr_valid = 1'b1;
      step();
      wr_valid = 1'b0;
   endtask

   task automatic wait_steps(input int n);
      int s;
      s = 0;
      while (s < n) begin
         @(negedge clk);
         if (str_seen) s++;
      end
      #1;
   endtask

   task automatic drain();
      while (qv.size() != 0) @(negedge clk);
      wait_steps(2);
   endtask

   task automatic clear_txc();
      txc_clr = 1'b1;
      step();
      txc_clr = 1'b0;
      chk(txc === 1'b0, "R8", "txc after clear", int'(txc), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      repeat (4) @(negedge clk);
      // R10: reset state
      chk(txd === 1'b1, "R10", "txd in reset", int'(txd), 1);
      chk(dre === 1'b1, "R10", "dre in reset", int'(dre), 1);
      chk(txc === 1'b0, "R10", "txc in reset", int'(txc), 0);
      chk(txd_oe === 1'b0, "R9", "oe while disabled", int'(txd_oe), 0);
      #1 rst_n = 1'b1;
      step();
      tx_en = 1'b1;
      wait_steps(3);
      chk(txd_oe === 1'b1, "R9", "oe while enabled", int'(txd_oe), 1);

      // asynchronous formats: widths, parity types, stop counts
      send(9'h015, 5, 0, 1'b0); drain(); clear_txc();
      send(9'h02A, 6, 2, 1'b0); drain(); clear_txc();
      send(9'h05B, 7, 3, 1'b1); drain(); clear_txc();
      send(9'h0A5, 8, 1, 1'b1); drain(); clear_txc();
      send(9'h1C3, 9, 2, 1'b0); drain(); clear_txc();
      send(9'h0FF, 8, 3, 1'b0); drain(); clear_txc();
      send(9'h100, 9, 3, 1'b1); drain(); clear_txc();
      send(9'h000, 8, 2, 1'b0); drain(); clear_txc();

      // R6 / R7: back-to-back frames, third write dropped
      send(9'h0C6, 8, 0, 1'b0);
      send(9'h039, 8, 0, 1'b0);
      chk(dre === 1'b0, "R7", "dre with char held", int'(dre), 0);
      poke(9'h1FF);
      drain(); clear_txc();

      // R11: write coinciding with a bit step while idle
      step();
      while (bit_tick !== 1'b1) step();
      len_sel = 3'd3; par_sel = 2'd0; stop2 = 1'b0;
      wr_data = 8'h5A; wr_msb = 1'b0; wr_valid = 1'b1;
      @(posedge clk);
      push_frame(9'h05A, 8, 0, 1'b0);
      @(negedge clk);
      chk(txd === 1'b0, "R11", "start at same step", int'(txd), 0);
      chk(dre === 1'b1, "R11", "dre stays high", int'(dre), 1);
      #1 wr_valid = 1'b0;
      drain(); clear_txc();

      // R5: clocked operation, both polarities
      sync_mode = 1'b1; xck_pol = 1'b0;
      wait_steps(2);
      send(9'h0B2, 8, 0, 1'b0); drain(); clear_txc();
      send(9'h04D, 7, 2, 1'b1); drain(); clear_txc();
      xck_pol = 1'b1;
      wait_steps(2);
      send(9'h16E, 9, 3, 1'b0); drain(); clear_txc();
      send(9'h013, 6, 0, 1'b1); drain(); clear_txc();
      sync_mode = 1'b0; xck_pol = 1'b0;
      wait_steps(2);

      // R9: abort mid-frame, writes dropped while disabled
      send(9'h1A5, 9, 2, 1'b1);
      wait_steps(4);
      step();
      tx_en = 1'b0;
      qv.delete(); qt.delete(); pend_end = 1'b0;
      step();
      chk(txd_oe === 1'b0, "R9", "oe after disable", int'(txd_oe), 0);
      chk(txd === 1'b1, "R9", "txd after abort", int'(txd), 1);
      chk(dre === 1'b1, "R9", "buffer emptied", int'(dre), 1);
      poke(9'h0AA);
      wait_steps(2);
      chk(dre === 1'b1, "R9", "write dropped while off", int'(dre), 1);
      tx_en = 1'b1;
      wait_steps(4);
      chk(txd === 1'b1, "R9", "no frame after re-enable", int'(txd), 1);
      chk(dre === 1'b1, "R9", "buffer still empty", int'(dre), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule